// File: doc/BRIEF.md
# Three-Channel Counter Host Register Interface

This block is the byte-wide host side of a three-channel interval counter. A two-bit address selects the target. Addresses 0, 1 and 2 reach the data port of channels 0 to 2. Address 3 is the write-only control port. The block decodes control words into per-channel settings. It turns single-byte or two-byte data writes into a 16-bit load strobe for the counting logic. It also serves reads from a per-channel status snapshot, a per-channel count snapshot, or the live count that the counting logic presents.

Each channel keeps its own count snapshot and its own status snapshot. Neither snapshot is overwritten while it is still unread. A read-back command on the control port can take snapshots of several channels in one write. Reads and writes each have their own byte pointer for two-byte access. The counting itself lies outside this block, which only samples each channel's live count and output level.

Top module: `ctr_host_regs`

## Requirements
- R1: After reset no load strobe is raised, every channel reports mode 0 and BCD 0, the access type is two-byte (low byte first), and no snapshot is pending.
- R2: A control write with bits 7:6 = channel n (0..2) and a non-zero access type in bits 5:4 sets that channel's access type, its mode (bits 3:1, shown on `chan_mode`) and its BCD flag (bit 0, shown on `chan_bcd`). Both byte pointers of that channel return to the low byte.
- R3: With access type 1 (low only), a data write loads {8'h00, byte}. With access type 2 (high only), it loads {byte, 8'h00}. `load_stb` of that channel alone is high for the one cycle after the write, and `load_val` holds the value.
- R4: With access type 3 (two-byte), the first data write only holds the byte and raises no strobe. The second write loads {second byte, first byte}.
- R5: A control write with access type 0 takes a snapshot of that channel's live count. Reads then return the snapshot according to the access type in effect when it was taken, whatever the live count does meanwhile.
- R6: A count snapshot request is ignored while an earlier count snapshot of that channel is still unread.
- R7: A read-back command (bits 7:6 = 3) acts on every channel whose select bit is set: bit 1 for channel 0, bit 2 for channel 1, bit 3 for channel 2. Bit 5 = 0 takes a count snapshot and bit 4 = 0 takes a status snapshot.
- R8: The status byte is {output level, 0, access type, mode, BCD} in bits 7, 6, 5:4, 3:1 and 0. A pending status snapshot is not overwritten by a further read-back.
- R9: A data read returns the pending status snapshot first and then clears it. Otherwise it returns the pending count snapshot. Otherwise it returns the live count.
- R10: Live count reads return the low byte for access type 1 and the high byte for access type 2. For access type 3 they alternate low, high, low, and so on.
- R11: A two-byte count snapshot is read as the low byte and then the high byte. The second read clears the snapshot. A single-byte snapshot is cleared by its one read.
- R12: A read of address 3 returns 0 and changes no read pointer or snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per byte |
| rd_en | input | 1 | Host read strobe, ignored when wr_en is high |
| addr | input | 2 | 0..2 channel data, 3 control |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Read byte for the current address, valid while rd_en is high |
| load_stb | output | NCH | Per-channel count load strobe |
| load_val | output | 16*NCH | Per-channel loaded 16-bit value |
| chan_mode | output | 3*NCH | Per-channel programmed mode |
| chan_bcd | output | NCH | Per-channel programmed BCD flag |
| live_cnt | input | 16*NCH | Per-channel current count from the counting logic |
| live_out | input | NCH | Per-channel output level from the counting logic |

## Verification
The hardest state to reach is a channel that holds a status snapshot and a two-byte count snapshot together, with the live count and output level already changed after both were taken. A single read-back command with both latch bits clear creates that state. The bench then moves the live inputs and issues a second read-back to show that neither snapshot is replaced. It then reads status, low byte, high byte and finally the live value in that order. Half-finished two-byte writes and reads, cut off by a new control word, reach the pointer-reset rule.

// File: rtl/ctr_host_pkg.sv
package ctr_host_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_WORD  = 2'd3
    } acc_e;

    typedef struct packed {
        acc_e               acc;
        logic [MODE_W-1:0]  mode;
        logic               bcd;
        logic               wr_hi;
        logic               rd_hi;
        logic [BYTE_W-1:0]  hold;
        acc_e               lat_st;
        logic [CNT_W-1:0]   lat_cnt;
        logic               st_v;
        logic [BYTE_W-1:0]  st;
        logic               ld;
        logic [CNT_W-1:0]   ld_val;
    } chan_st_t;

endpackage

// File: rtl/ctr_host_decode.sv
module ctr_host_decode
    import ctr_host_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [NCH-1:0]    ctl_wr,
    output logic [NCH-1:0]    lat_cnt,
    output logic [NCH-1:0]    lat_st,
    output logic [NCH-1:0]    dat_wr,
    output logic [NCH-1:0]    dat_rd
);

    localparam logic [1:0] CTL_ADDR = 2'd3;
    localparam logic [1:0] RB_SEL   = 2'd3;

    logic       ctl;
    logic       rb;
    logic [1:0] sel;
    logic [1:0] acc;

    assign ctl = wr_en && (addr == CTL_ADDR);
    assign sel = wdata[7:6];
    assign acc = wdata[5:4];
    assign rb  = (sel == RB_SEL);

    for (genvar i = 0; i < NCH; i++) begin : g_dec
        localparam logic [1:0] IDX = 2'(i);
        logic hit;
        assign hit        = ctl && !rb && (sel == IDX);
        assign ctl_wr[i]  = hit && (acc != 2'd0);
        assign lat_cnt[i] = (hit && (acc == 2'd0)) ||
                            (ctl && rb && wdata[1+i] && !wdata[5]);
        assign lat_st[i]  = ctl && rb && wdata[1+i] && !wdata[4];
        assign dat_wr[i]  = wr_en && (addr == IDX);
        assign dat_rd[i]  = rd_en && !wr_en && (addr == IDX);
    end

endmodule

// File: rtl/ctr_host_chan.sv
module ctr_host_chan
    import ctr_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              lat_cnt,
    input  logic              lat_st,
    input  logic              dat_wr,
    input  logic              dat_rd,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic [CNT_W-1:0]  live_cnt,
    input  logic              live_out,
    output logic [BYTE_W-1:0] rbyte,
    output logic              load_stb,
    output logic [CNT_W-1:0]  load_val,
    output logic [MODE_W-1:0] mode,
    output logic              bcd
);

    chan_st_t st_d, st_q;

    // next-state computation
    always_comb begin
        st_d    = st_q;
        st_d.ld = 1'b0;

        if (ctl_wr) begin
            st_d.acc   = acc_e'(wbyte[5:4]);
            st_d.mode  = wbyte[3:1];
            st_d.bcd   = wbyte[0];
            st_d.wr_hi = 1'b0;
            st_d.rd_hi = 1'b0;
        end

        if (lat_cnt && (st_q.lat_st == ACC_LATCH)) begin
            st_d.lat_st  = st_q.acc;
            st_d.lat_cnt = live_cnt;
        end

        if (lat_st && !st_q.st_v) begin
            st_d.st_v = 1'b1;
            st_d.st   = {live_out, 1'b0, st_q.acc, st_q.mode, st_q.bcd};
        end

        if (dat_wr) begin
            case (st_q.acc)
                ACC_LO: begin
                    st_d.ld     = 1'b1;
                    st_d.ld_val = {{BYTE_W{1'b0}}, wbyte};
                end
                ACC_HI: begin
                    st_d.ld     = 1'b1;
                    st_d.ld_val = {wbyte, {BYTE_W{1'b0}}};
                end
                default: begin
                    if (!st_q.wr_hi) begin
                        st_d.hold  = wbyte;
                        st_d.wr_hi = 1'b1;
                    end else begin
                        st_d.ld     = 1'b1;
                        st_d.ld_val = {wbyte, st_q.hold};
                        st_d.wr_hi  = 1'b0;
                    end
                end
            endcase
        end

        if (dat_rd) begin
            if (st_q.st_v) begin
                st_d.st_v = 1'b0;
            end else if (st_q.lat_st != ACC_LATCH) begin
                st_d.lat_st = (st_q.lat_st == ACC_WORD) ? ACC_HI : ACC_LATCH;
            end else if (st_q.acc == ACC_WORD) begin
                st_d.rd_hi = !st_q.rd_hi;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.acc    <= ACC_WORD;
            st_q.lat_st <= ACC_LATCH;
        end else begin
            st_q <= st_d;
        end
    end

    // read byte selection: status, then count snapshot, then live count
    always_comb begin
        if (st_q.st_v) begin
            rbyte = st_q.st;
        end else begin
            case (st_q.lat_st)
                ACC_LO, ACC_WORD: rbyte = st_q.lat_cnt[BYTE_W-1:0];
                ACC_HI:           rbyte = st_q.lat_cnt[CNT_W-1:BYTE_W];
                default: begin
                    case (st_q.acc)
                        ACC_HI:  rbyte = live_cnt[CNT_W-1:BYTE_W];
                        ACC_LO:  rbyte = live_cnt[BYTE_W-1:0];
                        default: rbyte = st_q.rd_hi ? live_cnt[CNT_W-1:BYTE_W]
                                                    : live_cnt[BYTE_W-1:0];
                    endcase
                end
            endcase
        end
    end

    assign load_stb = st_q.ld;
    assign load_val = st_q.ld_val;
    assign mode     = st_q.mode;
    assign bcd      = st_q.bcd;

    assert_ptr_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (!st_q.wr_hi && !st_q.rd_hi));

    assert_lo_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && st_q.acc == ACC_LO) |=>
            (load_stb && load_val == {{BYTE_W{1'b0}}, $past(wbyte)}));

    assert_hi_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && st_q.acc == ACC_HI) |=>
            (load_stb && load_val == {$past(wbyte), {BYTE_W{1'b0}}}));

    assert_word_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && st_q.acc == ACC_WORD && !st_q.wr_hi) |=> !load_stb);

    assert_word_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && st_q.acc == ACC_WORD && st_q.wr_hi) |=>
            (load_stb && load_val[BYTE_W-1:0] == $past(st_q.hold)));

    assert_latch_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_cnt && st_q.lat_st != ACC_LATCH) |=> $stable(st_q.lat_cnt));

    assert_status_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_st && st_q.st_v && !dat_rd) |=> $stable(st_q.st));

    assert_status_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_rd && st_q.st_v) |=> $stable(st_q.lat_st));

endmodule

// File: rtl/ctr_host_regs.sv
module ctr_host_regs
    import ctr_host_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [1:0]            addr,
    input  logic [7:0]            wdata,
    output logic [7:0]            rdata,
    output logic [NCH-1:0]        load_stb,
    output logic [16*NCH-1:0]     load_val,
    output logic [3*NCH-1:0]      chan_mode,
    output logic [NCH-1:0]        chan_bcd,
    input  logic [16*NCH-1:0]     live_cnt,
    input  logic [NCH-1:0]        live_out
);

    logic [NCH-1:0]    ctl_wr, lat_cnt, lat_st, dat_wr, dat_rd;
    logic [BYTE_W-1:0] rbyte [NCH];

    ctr_host_decode #(.NCH(NCH)) decode_i (
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .ctl_wr  (ctl_wr),
        .lat_cnt (lat_cnt),
        .lat_st  (lat_st),
        .dat_wr  (dat_wr),
        .dat_rd  (dat_rd)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        ctr_host_chan chan_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctl_wr   (ctl_wr[i]),
            .lat_cnt  (lat_cnt[i]),
            .lat_st   (lat_st[i]),
            .dat_wr   (dat_wr[i]),
            .dat_rd   (dat_rd[i]),
            .wbyte    (wdata),
            .live_cnt (live_cnt[CNT_W*i +: CNT_W]),
            .live_out (live_out[i]),
            .rbyte    (rbyte[i]),
            .load_stb (load_stb[i]),
            .load_val (load_val[CNT_W*i +: CNT_W]),
            .mode     (chan_mode[MODE_W*i +: MODE_W]),
            .bcd      (chan_bcd[i])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (addr == 2'(i)) rdata = rbyte[i];
        end
    end

    assert_ctl_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == 2'd3) |=> $stable(dat_rd) || (dat_rd == '0));

    assert_strobe_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_stb));

endmodule

// File: tb/ctr_host_regs_tb_top.sv
module ctr_host_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [2:0]  load_stb;
    logic [47:0] load_val;
    logic [8:0]  chan_mode;
    logic [2:0]  chan_bcd;
    logic [15:0] lc [3];
    logic [2:0]  live_out = '0;
    logic [47:0] live_cnt;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    int acc_m [3];
    int mode_m [3];
    int bcd_m [3];

    assign live_cnt = {lc[2], lc[1], lc[0]};

    always #5 clk = ~clk;

    ctr_host_regs #(.NCH(3)) dut_i (
        .clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata,
        .load_stb, .load_val, .chan_mode, .chan_bcd, .live_cnt, .live_out
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input int a, input logic [7:0] d);
        @(negedge clk);
        addr  = 2'(a);
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input int a, output logic [7:0] d);
        @(negedge clk);
        addr  = 2'(a);
        rd_en = 1'b1;
        #1;
        d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic logic [7:0] ctlw(input int ch, input int a, input int m,
                                        input int b);
        return {2'(ch), 2'(a), 3'(m), 1'(b)};
    endfunction

    task automatic prog(input int ch, input int a, input int m, input int b);
        do_wr(3, ctlw(ch, a, m, b));
        acc_m[ch]  = a;
        mode_m[ch] = m;
        bcd_m[ch]  = b;
    endtask

    function automatic logic [7:0] stat_exp(input int ch, input logic o);
        return {o, 1'b0, 2'(acc_m[ch]), 3'(mode_m[ch]), 1'(bcd_m[ch])};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog act=%h exp=%h", 16'd0, 16'd1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [7:0]  r, r2;
        logic [15:0] v, old;
        for (int c = 0; c < 3; c++) begin
            lc[c] = 16'h1111 * 16'(c + 1);
            acc_m[c] = 3; mode_m[c] = 0; bcd_m[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk(load_stb == 3'b0, "R1 no strobe", 16'(load_stb), 16'h0);
        chk(chan_mode == 9'b0 && chan_bcd == 3'b0, "R1 mode/bcd", 16'(chan_mode), 16'h0);
        lc[0] = 16'hA55A;
        do_rd(0, r);
        chk(r == 8'h5A, "R1 word low first", 16'(r), 16'h5A);
        do_rd(0, r);
        chk(r == 8'hA5, "R1 word high second", 16'(r), 16'hA5);

        // R2, R3, R4: control decode and write loads, all channels and access types
        for (int c = 0; c < 3; c++) begin
            for (int a = 1; a < 4; a++) begin
                int m = (c + a) % 6;
                int b = a % 2;
                prog(c, a, m, b);
                chk(chan_mode[3*c +: 3] == 3'(m), "R2 mode", 16'(chan_mode[3*c +: 3]), 16'(m));
                chk(chan_bcd[c] == 1'(b), "R2 bcd", 16'(chan_bcd[c]), 16'(b));
                for (int p = 0; p < 4; p++) begin
                    v = 16'h1357 * 16'(p + 1) ^ 16'(c << 12);
                    if (a == 1) begin
                        do_wr(c, v[7:0]);
                        chk(load_stb == 3'(1 << c) && load_val[16*c +: 16] == {8'h00, v[7:0]},
                            "R3 low-only load", load_val[16*c +: 16], {8'h00, v[7:0]});
                    end else if (a == 2) begin
                        do_wr(c, v[7:0]);
                        chk(load_stb == 3'(1 << c) && load_val[16*c +: 16] == {v[7:0], 8'h00},
                            "R3 high-only load", load_val[16*c +: 16], {v[7:0], 8'h00});
                    end else begin
                        do_wr(c, v[7:0]);
                        chk(load_stb == 3'b0, "R4 first byte held", 16'(load_stb), 16'h0);
                        do_wr(c, v[15:8]);
                        chk(load_stb == 3'(1 << c) && load_val[16*c +: 16] == v,
                            "R4 word load", load_val[16*c +: 16], v);
                    end
                    @(negedge clk);
                    chk(load_stb == 3'b0, "R3 strobe one cycle", 16'(load_stb), 16'h0);
                end
            end
        end

        // R2: a control word resets a half-done write pointer
        prog(1, 3, 2, 0);
        do_wr(1, 8'hEE);
        prog(1, 3, 2, 0);
        do_wr(1, 8'h34);
        chk(load_stb == 3'b0, "R2 write pointer reset", 16'(load_stb), 16'h0);
        do_wr(1, 8'h12);
        chk(load_val[31:16] == 16'h1234, "R2 write pointer reset value", load_val[31:16], 16'h1234);

        // R10: live reads in each access type
        for (int c = 0; c < 3; c++) begin
            prog(c, 1, 0, 0);
            lc[c] = 16'hC0DE + 16'(c);
            do_rd(c, r);
            chk(r == lc[c][7:0], "R10 low only", 16'(r), 16'(lc[c][7:0]));
            do_rd(c, r);
            chk(r == lc[c][7:0], "R10 low only repeat", 16'(r), 16'(lc[c][7:0]));
            prog(c, 2, 0, 0);
            do_rd(c, r);
            chk(r == lc[c][15:8], "R10 high only", 16'(r), 16'(lc[c][15:8]));
            prog(c, 3, 0, 0);
            for (int k = 0; k < 4; k++) begin
                lc[c] = 16'h2468 + 16'(k * 16'h0F0F);
                do_rd(c, r);
                if (k % 2 == 0)
                    chk(r == lc[c][7:0], "R10 word alternate low", 16'(r), 16'(lc[c][7:0]));
                else
                    chk(r == lc[c][15:8], "R10 word alternate high", 16'(r), 16'(lc[c][15:8]));
            end
        end

        // R2: a control word resets a half-done read pointer
        lc[2] = 16'hBEEF;
        do_rd(2, r);
        prog(2, 3, 0, 0);
        do_rd(2, r);
        chk(r == 8'hEF, "R2 read pointer reset", 16'(r), 16'hEF);
        do_rd(2, r);

        // R5, R11, R6: count snapshots
        prog(0, 3, 4, 1);
        lc[0] = 16'h4321;
        do_wr(3, ctlw(0, 0, 0, 0));
        lc[0] = 16'h9999;
        do_wr(3, ctlw(0, 0, 0, 0));
        lc[0] = 16'h7777;
        do_rd(0, r);
        chk(r == 8'h21, "R5 R6 latched low kept", 16'(r), 16'h21);
        do_rd(0, r);
        chk(r == 8'h43, "R11 latched high", 16'(r), 16'h43);
        do_rd(0, r);
        chk(r == 8'h77, "R11 latch cleared to live", 16'(r), 16'h77);
        do_rd(0, r);

        prog(1, 2, 1, 0);
        lc[1] = 16'h5A3C;
        do_wr(3, ctlw(1, 0, 0, 0));
        prog(1, 1, 1, 0);
        lc[1] = 16'h0102;
        do_rd(1, r);
        chk(r == 8'h5A, "R5 snapshot keeps its access type", 16'(r), 16'h5A);
        do_rd(1, r);
        chk(r == 8'h02, "R11 single-byte latch cleared", 16'(r), 16'h02);

        // R7, R8, R9: read-back of channels 0 and 2, status and count
        prog(0, 3, 5, 0);
        prog(1, 3, 1, 1);
        prog(2, 1, 3, 1);
        lc[0] = 16'hAB12; lc[1] = 16'hCD34; lc[2] = 16'hEF56;
        live_out = 3'b101;
        do_wr(3, 8'b1100_1010);
        lc[0] = 16'h0000; lc[1] = 16'h1188; lc[2] = 16'h0000;
        live_out = 3'b000;
        do_wr(3, 8'b1110_1010);
        do_rd(0, r);
        chk(r == stat_exp(0, 1'b1), "R8 R9 status first ch0", 16'(r), 16'(stat_exp(0, 1'b1)));
        do_rd(0, r);
        chk(r == 8'h12, "R9 count after status ch0", 16'(r), 16'h12);
        do_rd(0, r);
        chk(r == 8'hAB, "R9 count high ch0", 16'(r), 16'hAB);
        do_rd(0, r);
        chk(r == 8'h00, "R9 live after snapshots ch0", 16'(r), 16'h00);
        do_rd(0, r);
        do_rd(1, r);
        chk(r == 8'h88, "R7 unselected channel live", 16'(r), 16'h88);
        do_rd(1, r);
        do_rd(2, r);
        chk(r == stat_exp(2, 1'b1), "R8 status ch2", 16'(r), 16'(stat_exp(2, 1'b1)));
        do_rd(2, r);
        chk(r == 8'h56, "R7 count ch2 low-only", 16'(r), 16'h56);

        // R7: count-only read-back on all three channels
        lc[0] = 16'h1020; lc[1] = 16'h3040; lc[2] = 16'h5060;
        do_wr(3, 8'b1101_1110);
        lc[0] = 16'h0; lc[1] = 16'h0; lc[2] = 16'h0;
        do_rd(0, r); do_rd(0, r2);
        chk({r2, r} == 16'h1020, "R7 count-only ch0", {r2, r}, 16'h1020);
        do_rd(1, r); do_rd(1, r2);
        chk({r2, r} == 16'h3040, "R7 count-only ch1", {r2, r}, 16'h3040);
        do_rd(2, r);
        chk(r == 8'h60, "R7 count-only ch2", 16'(r), 16'h60);

        // R12: control address read
        prog(0, 3, 0, 0);
        lc[0] = 16'h6655;
        do_rd(0, r);
        do_rd(3, r);
        chk(r == 8'h00, "R12 control read zero", 16'(r), 16'h00);
        do_rd(0, r);
        chk(r == 8'h66, "R12 no pointer change", 16'(r), 16'h66);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule